// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block turns the configuration of a bank of memory-protection entries into explicit byte-address bounds. For each entry it reads a two-bit match mode from the entry's config byte, the entry's own address register and the address register of the entry just below it. From these it produces an inclusive lower bound and an inclusive upper bound, one per entry. A downstream comparator then checks an access against these bounds without doing any decoding of its own.

Address registers hold byte addresses divided by four, so the bounds are two bits wider than the registers. Three region shapes are decoded. A top-of-range entry spans from the lower neighbour's address up to just below its own address. A four-byte entry covers one naturally aligned word. A power-of-two entry covers a naturally aligned region whose size comes from the count of trailing ones in its register. The block also flags which entries can match at all, and counts the entries whose mode is not off.

The block is purely combinational and has no storage. It is meant to sit between the protection register file and the access checker, and it decodes again whenever a register changes.

Top module: `pmp_bound_decode`

## Requirements
- R1: Each entry's match mode is bits [4:3] of its config byte, encoded off=0, top-of-range=1, four-byte=2, power-of-two=3. The other config bits have no effect on any output.
- R2: In top-of-range mode the lower bound is 4 × (address register of entry i−1) and the upper bound is 4 × (own address register) − 1, taken modulo 2^(XLEN+2). Entry 0 uses 0 as the neighbour address.
- R3: A top-of-range entry is marked live only when its own address register is strictly greater than the neighbour's. An entry whose own register is 0 or not above the neighbour is an empty region and is not live.
- R4: In four-byte mode the lower bound is 4 × address and the upper bound is that value plus 3. The entry is live.
- R5: In power-of-two mode, with k trailing ones in the address register, the region is 2^(k+3) bytes, aligned to its size, and contains 4 × address. The lower bound is the aligned base and the upper bound is base + size − 1. The entry is live.
- R6: No bound wraps around. An all-ones or 0111…1 register in power-of-two mode gives lower bound 0 and an all-ones upper bound. An all-ones register in four-byte mode gives an all-ones upper bound.
- R7: In off mode the bounds are 0 and all-ones, and the entry is never live.
- R8: The active count equals the number of entries whose mode is not off, whether or not their regions are empty.
- R9: All outputs are combinational functions of the current inputs, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_i | input | NUM_ENT*8 | Config bytes; entry i in bits [8i+7:8i] |
| addr_i | input | NUM_ENT*XLEN | Address registers (byte address / 4); entry i in slice i |
| lo_o | output | NUM_ENT*(XLEN+2) | Inclusive lower byte bound per entry |
| hi_o | output | NUM_ENT*(XLEN+2) | Inclusive upper byte bound per entry |
| live_o | output | NUM_ENT | Entry can match an access (non-off and non-empty) |
| active_cnt_o | output | $clog2(NUM_ENT+1) | Number of entries whose mode is not off |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench therefore changes all inputs just after a falling clock edge and samples one nanosecond later, well before the next rising edge. This lets the decode logic settle, and no check depends on how processes are ordered at a clock edge. The expected bounds come from a bench model that counts trailing ones and adds the region size. It does not use the AND/OR carry method of the design, so the two computations are independent.

// File: rtl/pmpd_pkg.sv
package pmpd_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    localparam int CFG_BITS = 8;
    localparam int MODE_LSB = 3;

    typedef struct packed {
        logic live;
        logic active;
    } ent_flags_t;

    function automatic match_mode_e mode_of(input logic [1:0] field);
        return match_mode_e'(field);
    endfunction

endpackage

// File: rtl/pmpd_entry.sv
module pmpd_entry
    import pmpd_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int BW  = XLEN + 2,
    localparam int WW  = XLEN + 3
) (
    input  logic [1:0]      mode_i,
    input  logic [XLEN-1:0] addr_i,
    input  logic [XLEN-1:0] prev_i,
    output logic [BW-1:0]   lo_o,
    output logic [BW-1:0]   hi_o,
    output ent_flags_t      flags_o
);

    localparam logic [WW-1:0] ONE_W  = WW'(1);
    localparam logic [BW-1:0] LOW2_W = BW'(3);

    match_mode_e     mode;
    logic [BW-1:0]   a4;
    logic [BW-1:0]   p4;
    logic [BW-1:0]   v_ones;
    logic [WW-1:0]   v_inc;
    logic [WW-1:0]   hi_w;
    logic [BW-1:0]   span;

    always_comb begin
        mode   = mode_of(mode_i);
        a4     = {addr_i, 2'b00};
        p4     = {prev_i, 2'b00};
        v_ones = a4 | LOW2_W;
        v_inc  = {1'b0, v_ones} + ONE_W;

        lo_o         = '0;
        hi_w         = {1'b0, {BW{1'b1}}};
        flags_o      = '0;

        unique case (mode)
            MATCH_OFF: begin
                lo_o         = '0;
                hi_w         = {1'b0, {BW{1'b1}}};
                flags_o.live = 1'b0;
            end
            MATCH_TOR: begin
                lo_o         = p4;
                hi_w         = {1'b0, a4} - ONE_W;
                flags_o.live = (addr_i > prev_i);
            end
            MATCH_NA4: begin
                lo_o         = a4;
                hi_w         = {1'b0, v_ones};
                flags_o.live = 1'b1;
            end
            MATCH_NAPOT: begin
                lo_o         = v_ones & v_inc[BW-1:0];
                hi_w         = {1'b0, v_ones} | v_inc;
                flags_o.live = 1'b1;
            end
            default: begin
                lo_o         = '0;
                hi_w         = '0;
                flags_o.live = 1'b0;
            end
        endcase

        flags_o.active = (mode != MATCH_OFF);
        hi_o           = hi_w[BW-1:0];
        span           = hi_o - lo_o;

        if (!$isunknown({mode_i, addr_i, prev_i})) begin
            // R4: a four-byte region always spans exactly three bytes past its base
            assert_na4_span_R4: assert (mode != MATCH_NA4 || span == BW'(3))
                else $error("four-byte region span wrong");
            // R5: power-of-two region has size 2^n and is aligned to it
            assert_napot_align_R5: assert (mode != MATCH_NAPOT ||
                (((span & (span + BW'(1))) == '0) && ((lo_o & span) == '0)))
                else $error("power-of-two region misshapen");
            // R3: a live top-of-range region is never inverted
            assert_tor_order_R3: assert (mode != MATCH_TOR || !flags_o.live || lo_o <= hi_o)
                else $error("live top-of-range region inverted");
            // R6: any carry out of the bound width saturates the upper bound
            assert_no_overflow_R6: assert (!hi_w[WW-1] || hi_o == {BW{1'b1}})
                else $error("upper bound wrapped");
            // R7: off entries must never be live
            assert_off_dead_R7: assert (mode != MATCH_OFF || (!flags_o.live && lo_o == '0))
                else $error("off entry live");
        end
    end

endmodule

// File: rtl/pmpd_popcount.sv
module pmpd_popcount #(
    parameter int N  = 16,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] cnt_o
);

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N; i++) begin
            cnt_o = cnt_o + CW'(bits_i[i]);
        end

        if (!$isunknown(bits_i)) begin
            // R8: the count never exceeds the number of entries
            assert_cnt_bound_R8: assert (cnt_o <= CW'(N))
                else $error("active count above entry total");
            // R8: zero count exactly when no entry is active
            assert_cnt_zero_R8: assert ((cnt_o == '0) == (bits_i == '0))
                else $error("active count zero mismatch");
        end
    end

endmodule

// File: rtl/pmp_bound_decode.sv
module pmp_bound_decode
    import pmpd_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int XLEN    = 32,
    localparam int BW     = XLEN + 2,
    localparam int CW     = $clog2(NUM_ENT + 1)
) (
    input  logic [NUM_ENT*CFG_BITS-1:0] cfg_i,
    input  logic [NUM_ENT*XLEN-1:0]     addr_i,
    output logic [NUM_ENT*BW-1:0]       lo_o,
    output logic [NUM_ENT*BW-1:0]       hi_o,
    output logic [NUM_ENT-1:0]          live_o,
    output logic [CW-1:0]               active_cnt_o
);

    logic [NUM_ENT-1:0] active_vec;
    logic [NUM_ENT-1:0] unused_cfg_bits;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        logic [XLEN-1:0] prev_addr;
        ent_flags_t      flags;

        if (g == 0) begin : g_first
            assign prev_addr = '0;
        end else begin : g_rest
            assign prev_addr = addr_i[(g-1)*XLEN +: XLEN];
        end

        assign unused_cfg_bits[g] = ^{cfg_i[g*CFG_BITS+CFG_BITS-1 : g*CFG_BITS+MODE_LSB+2],
                                      cfg_i[g*CFG_BITS+MODE_LSB-1 : g*CFG_BITS]};

        pmpd_entry #(.XLEN(XLEN)) u_entry (
            .mode_i  (cfg_i[g*CFG_BITS+MODE_LSB +: 2]),
            .addr_i  (addr_i[g*XLEN +: XLEN]),
            .prev_i  (prev_addr),
            .lo_o    (lo_o[g*BW +: BW]),
            .hi_o    (hi_o[g*BW +: BW]),
            .flags_o (flags)
        );

        assign live_o[g]     = flags.live;
        assign active_vec[g] = flags.active;
    end

    pmpd_popcount #(.N(NUM_ENT)) u_count (
        .bits_i (active_vec),
        .cnt_o  (active_cnt_o)
    );

endmodule

// File: tb/pmp_bound_decode_tb.sv
module pmp_bound_decode_tb;

    localparam int NE = 16;
    localparam int XL = 32;
    localparam int BW = XL + 2;
    localparam int CW = $clog2(NE + 1);
    localparam logic [63:0] BMASK = (64'd1 << BW) - 64'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NE*8-1:0]  cfg_i;
    logic [NE*XL-1:0] addr_i;
    logic [NE*BW-1:0] lo_o;
    logic [NE*BW-1:0] hi_o;
    logic [NE-1:0]    live_o;
    logic [CW-1:0]    active_cnt_o;

    logic [7:0]    cfg_m  [NE];
    logic [XL-1:0] addr_m [NE];

    int n_cmp  = 0;
    int n_fail = 0;

    pmp_bound_decode #(.NUM_ENT(NE), .XLEN(XL)) u_dut (
        .cfg_i        (cfg_i),
        .addr_i       (addr_i),
        .lo_o         (lo_o),
        .hi_o         (hi_o),
        .live_o       (live_o),
        .active_cnt_o (active_cnt_o)
    );

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NE; i++) begin
            cfg_m[i]  = 8'h00;
            addr_m[i] = '0;
        end
    endtask

    // Drive on falling edge, sample 1 ns later (R9: zero latency)
    task automatic apply();
        @(negedge clk);
        for (int i = 0; i < NE; i++) begin
            cfg_i[i*8 +: 8]   = cfg_m[i];
            addr_i[i*XL +: XL] = addr_m[i];
        end
        #1;
    endtask

    function automatic logic [63:0] ones_run(input logic [XL-1:0] a);
        int k = 0;
        while (k < XL && a[k]) k++;
        return 64'(k);
    endfunction

    task automatic check_all(input string tag);
        int exp_cnt = 0;
        for (int i = 0; i < NE; i++) begin
            logic [1:0]  md;
            logic [63:0] a4, p4, e_lo, e_hi, sz;
            logic        e_live;
            md = cfg_m[i][4:3];
            a4 = 64'(addr_m[i]) << 2;
            p4 = (i == 0) ? 64'd0 : (64'(addr_m[i-1]) << 2);
            case (md)
                2'd1: begin e_lo = p4; e_hi = (a4 - 64'd1) & BMASK;
                      e_live = (i == 0) ? (addr_m[i] != '0) : (addr_m[i] > addr_m[i-1]); end
                2'd2: begin e_lo = a4; e_hi = a4 + 64'd3; e_live = 1'b1; end
                2'd3: begin sz = 64'd1 << (ones_run(addr_m[i]) + 64'd3);
                      e_lo = a4 & ~(sz - 64'd1); e_hi = (e_lo + sz - 64'd1) & BMASK;
                      e_live = 1'b1; end
                default: begin e_lo = 64'd0; e_hi = BMASK; e_live = 1'b0; end
            endcase
            if (md != 2'd0) exp_cnt++;
            cmp($sformatf("%s lo[%0d]", tag, i), 64'(lo_o[i*BW +: BW]), e_lo);
            cmp($sformatf("%s hi[%0d]", tag, i), 64'(hi_o[i*BW +: BW]), e_hi);
            cmp($sformatf("%s live[%0d]", tag, i), 64'(live_o[i]), 64'(e_live));
        end
        cmp($sformatf("%s R8 count", tag), 64'(active_cnt_o), 64'(exp_cnt));
    endtask

    task automatic t_reset_state();
        clear_model(); apply();
        check_all("R7 reset all-off");
    endtask

    task automatic t_tor_chain();
        clear_model();
        for (int i = 0; i < 4; i++) begin
            cfg_m[i]  = 8'h08;
            addr_m[i] = 32'h0000_0100 * (i + 1);
        end
        apply(); check_all("R2 tor chain entry0 prev zero");
    endtask

    task automatic t_tor_empty();
        clear_model();
        addr_m[4] = 32'h0000_0100;
        cfg_m[5] = 8'h08; addr_m[5] = 32'h0000_0000;
        cfg_m[6] = 8'h08; addr_m[6] = 32'h0000_0080;
        cfg_m[7] = 8'h08; addr_m[7] = 32'h0000_0080;
        cfg_m[0] = 8'h08; addr_m[0] = 32'h0;
        apply(); check_all("R3 tor empty");
    endtask

    task automatic t_na4();
        clear_model();
        cfg_m[0] = 8'h10; addr_m[0] = 32'h0000_0000;
        cfg_m[1] = 8'h10; addr_m[1] = 32'h1234_5678;
        cfg_m[2] = 8'h10; addr_m[2] = 32'hFFFF_FFFF;
        apply(); check_all("R4 R6 four-byte");
    endtask

    task automatic t_napot_sizes();
        clear_model();
        for (int k = 0; k < 12; k++) begin
            cfg_m[k]  = 8'h18;
            addr_m[k] = (32'hA5A5_0000 & ~((32'd1 << (k + 1)) - 32'd1)) | ((32'd1 << k) - 32'd1);
        end
        apply(); check_all("R5 napot sizes");
    endtask

    task automatic t_napot_full();
        clear_model();
        cfg_m[0] = 8'h18; addr_m[0] = 32'hFFFF_FFFF;
        cfg_m[1] = 8'h18; addr_m[1] = 32'h7FFF_FFFF;
        cfg_m[2] = 8'h18; addr_m[2] = 32'h3FFF_FFFF;
        cfg_m[3] = 8'h18; addr_m[3] = 32'hBFFF_FFFF;
        apply(); check_all("R6 napot full range");
    endtask

    task automatic t_other_bits();
        clear_model();
        for (int i = 0; i < NE; i++) begin
            cfg_m[i]  = 8'hE7 | (8'((i % 4)) << 3);
            addr_m[i] = 32'h0101_0101 * (i + 3) + 32'(i);
        end
        apply(); check_all("R1 R7 other cfg bits ignored");
    endtask

    task automatic t_counts();
        for (int p = 0; p < 4; p++) begin
            clear_model();
            for (int i = 0; i < NE; i++) begin
                cfg_m[i]  = ((i * (p + 1)) % 3 == 0) ? 8'h00 : 8'(((i + p) % 3) + 1) << 3;
                addr_m[i] = 32'h0000_1000 + 32'(i * 16 * (p + 1));
            end
            apply(); check_all($sformatf("R8 count pattern %0d", p));
        end
        clear_model();
        for (int i = 0; i < NE; i++) cfg_m[i] = 8'h18;
        apply(); check_all("R8 count all active");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        cfg_i  = '0;
        addr_i = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_tor_chain();
        t_tor_empty();
        t_na4();
        t_napot_sizes();
        t_napot_full();
        t_other_bits();
        t_counts();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule